// File: doc/BRIEF.md
# Clock Power Management Controller

This block sits between two multi-purpose control pins and the clock sources and output pads of a clock generator. It decides when the reference oscillator and the three synthesized sources (CPU, system, utility) run. It also decides which of the six clock outputs drive and which are tri-stated. A tri-stated output is modelled as reading logic low, because each pad has a weak pull-down. Both pins pass through a two-flop synchronizer before they are decoded.

The active-low enable pin `oe_pin` always tri-states every output when it is low. When `cfg_sd_en` is set, a low on that pin also powers the chip down: every source stops and its lock state is lost. The top select bit `sel_pin[2]` is either a plain frequency select bit or, when `cfg_susp_en` is set, an active-low suspend request. Suspend stops a configured set of synthesized sources and tri-states a configured set of outputs. Any output whose mapped source is stopped is forced off, even if its own suspend bit is clear. After any restart, a source counts a configured number of prescaled reference ticks before it raises its ready flag. Its outputs stay tri-stated until that flag is set.

A four-state machine orders the power sequence:
- WAKE: sources are waiting to lock. It is entered from reset and from DOWN when the pin returns high. It moves to RUN once every running source is ready.
- RUN: normal operation.
- TRIST: the pin is low and shutdown is not enabled. Outputs are off and the sources keep running. It returns to RUN, or to WAKE if any running source is not ready, when the pin goes high.
- DOWN: the pin is low and shutdown is enabled. Everything is stopped. It leaves for WAKE when the pin goes high, or for TRIST if `cfg_sd_en` is cleared.

From WAKE or RUN, a low pin leads to DOWN or TRIST, depending on `cfg_sd_en`.

Top module: `clkpm_ctrl`

## Requirements
- R1: Once `oe_pin` has been low at two consecutive rising edges, every bit of `out_oe` and `out_val` is 0, in both shutdown modes.
- R2: With `cfg_sd_en`=1, a low `oe_pin` drives all four `src_run` bits to 0 and clears all `src_ready` bits. With `cfg_sd_en`=0, a low `oe_pin` leaves all sources running and keeps their ready flags.
- R3: One tick occurs every TICK_DIV cycles while the reference runs. After a source starts running, its `src_ready` bit rises after the source's wait count of ticks (WAIT_REF, WAIT_CPU, WAIT_SYS, WAIT_UTIL). It is never 1 while the source is stopped, and it is 0 again the cycle after the source stops. After a shutdown release, the bit is still 0 (WAIT−1)·TICK_DIV cycles after the pin rises and is 1 by WAIT·TICK_DIV+4 cycles after.
- R4: Output k drives only while its mapped source is both running and ready. The source is given by the 2-bit field `cfg_out_src[2k+1:2k]`, coded 0 = reference, 1 = CPU, 2 = system, 3 = utility. The `src_run`/`src_ready` bit positions follow the same codes.
- R5: Suspend is active when `cfg_susp_en`=1 and the synchronized `sel_pin[2]` is 0. While it is active, a source whose `cfg_susp_src` bit is set stops (bit 0 = CPU, bit 1 = system, bit 2 = utility), and an output whose `cfg_susp_out[k]` bit is set is tri-stated. The reference never suspends.
- R6: An output mapped to a suspended source is tri-stated even when its own `cfg_susp_out` bit is 0.
- R7: `sel_out` is `sel_pin` delayed by the two synchronizer flops. When `cfg_susp_en`=1, `sel_out[2]` is 0. When `cfg_susp_en`=0, `sel_pin[2]` has no effect on `src_run` or `out_oe`.
- R8: `out_val[k]` equals `raw_clk[k]` while output k drives, and is 0 while it is tri-stated.
- R9: During reset, `out_oe`=0, `src_ready`=0, and all sources are requested to run, ready to begin locking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-derived control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_pin | input | 1 | Active-low output enable / shutdown pin |
| sel_pin | input | 3 | Frequency select; bit 2 may act as active-low suspend |
| cfg_sd_en | input | 1 | 1: a low `oe_pin` also powers down all sources |
| cfg_susp_en | input | 1 | 1: `sel_pin[2]` is a suspend request |
| cfg_susp_src | input | 3 | Sources stopped by suspend (CPU, system, utility) |
| cfg_susp_out | input | 6 | Outputs tri-stated by suspend |
| cfg_out_src | input | 12 | 2-bit source code per output |
| raw_clk | input | 6 | Per-output clock level from the synthesis path |
| sel_out | output | 3 | Synchronized select bits to the CPU source |
| src_run | output | 4 | Run enable per source (ref, CPU, system, utility) |
| src_ready | output | 4 | Lock-wait expired per source |
| out_oe | output | 6 | 1 = output drives, 0 = tri-stated |
| out_val | output | 6 | Level seen on each output pad |

## Verification
Directed sequences exercise each pin role separately:
- tri-state-only versus full shutdown, which tells apart whether lock state survives a low enable pin;
- a release from shutdown sampled just before and just after the CPU wait, which separates the long CPU wait from the short system and utility waits;
- suspend with a source mask and a disjoint output mask, which tells the forced-off rule apart from the plain output mask;
- select pass-through with suspend on and off.

Random rounds then mix the pin levels, the masks, the output-to-source map and both mode bits. Each round lets the block settle and compares every output with bench-computed values, which catches wrong mappings and mask decoding.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
    localparam int N_SRC = 4;   // 0 ref, 1 cpu, 2 sys, 3 util
    localparam int N_OUT = 6;
    localparam int SEL_W = 3;
    localparam int MAP_W = $clog2(N_SRC);

    typedef enum logic [1:0] {
        PM_WAKE  = 2'd0,
        PM_RUN   = 2'd1,
        PM_TRIST = 2'd2,
        PM_DOWN  = 2'd3
    } pm_state_t;
endpackage

// File: rtl/clkpm_sync.sv
// Two-flop synchronizer; resets to all ones (inactive level of the low-true controls).
module clkpm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/clkpm_lock.sv
// Counts LIMIT ticks while the source runs, then holds ready until it stops.
module clkpm_lock #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic ready
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!run) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (tick && !ready) begin
            if (cnt == CW'(LIMIT - 1)) begin
                ready <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
    import clkpm_pkg::*;
#(
    parameter int TICK_DIV  = 8,
    parameter int WAIT_REF  = 2,
    parameter int WAIT_CPU  = 50,
    parameter int WAIT_SYS  = 1,
    parameter int WAIT_UTIL = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   oe_pin,
    input  logic [SEL_W-1:0]       sel_pin,
    input  logic                   cfg_sd_en,
    input  logic                   cfg_susp_en,
    input  logic [N_SRC-2:0]       cfg_susp_src,
    input  logic [N_OUT-1:0]       cfg_susp_out,
    input  logic [N_OUT*MAP_W-1:0] cfg_out_src,
    input  logic [N_OUT-1:0]       raw_clk,
    output logic [SEL_W-1:0]       sel_out,
    output logic [N_SRC-1:0]       src_run,
    output logic [N_SRC-1:0]       src_ready,
    output logic [N_OUT-1:0]       out_oe,
    output logic [N_OUT-1:0]       out_val
);
    localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

    // ---------------- synchronized pins ----------------
    logic [SEL_W:0]   pins_q;
    logic             oe_s;
    logic [SEL_W-1:0] sel_s;
    logic             susp_act;

    clkpm_sync #(.W(SEL_W + 1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({oe_pin, sel_pin}),
        .q     (pins_q)
    );

    assign oe_s     = pins_q[SEL_W];
    assign sel_s    = pins_q[SEL_W-1:0];
    assign susp_act = cfg_susp_en & ~sel_s[SEL_W-1];

    always_comb begin
        sel_out = sel_s;
        if (cfg_susp_en) sel_out[SEL_W-1] = 1'b0;
    end

    // ---------------- power sequencing FSM ----------------
    pm_state_t state, state_nx;
    logic      all_ok;

    assign all_ok = &(src_ready | ~src_run);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_WAKE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PM_WAKE: begin
                if (!oe_s)       state_nx = cfg_sd_en ? PM_DOWN : PM_TRIST;
                else if (all_ok) state_nx = PM_RUN;
            end
            PM_RUN: begin
                if (!oe_s)       state_nx = cfg_sd_en ? PM_DOWN : PM_TRIST;
            end
            PM_TRIST: begin
                if (!oe_s && cfg_sd_en) state_nx = PM_DOWN;
                else if (oe_s)          state_nx = all_ok ? PM_RUN : PM_WAKE;
            end
            PM_DOWN: begin
                if (oe_s)            state_nx = PM_WAKE;
                else if (!cfg_sd_en) state_nx = PM_TRIST;
            end
        endcase
    end

    // ---------------- state outputs ----------------
    logic powered_down;
    logic drive_ok;

    always_comb begin
        powered_down = (state == PM_DOWN);
        drive_ok     = oe_s && ((state == PM_RUN) || (state == PM_WAKE));
        src_run[0]   = !powered_down;
        for (int i = 1; i < N_SRC; i++) begin
            src_run[i] = !powered_down && !(susp_act && cfg_susp_src[i-1]);
        end
    end

    // ---------------- reference tick prescaler ----------------
    logic [TW-1:0] pre_cnt;
    logic          tick;

    assign tick = src_run[0] && (pre_cnt == TW'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pre_cnt <= '0;
        else if (!src_run[0]) pre_cnt <= '0;
        else if (tick)        pre_cnt <= '0;
        else                  pre_cnt <= pre_cnt + 1'b1;
    end

    // ---------------- per-source lock waits ----------------
    for (genvar i = 0; i < N_SRC; i++) begin : g_lock
        localparam int LIM = (i == 0) ? WAIT_REF :
                             (i == 1) ? WAIT_CPU :
                             (i == 2) ? WAIT_SYS : WAIT_UTIL;
        clkpm_lock #(.LIMIT(LIM)) u_lock (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (src_run[i]),
            .tick  (tick),
            .ready (src_ready[i])
        );
    end

    // ---------------- per-output enables ----------------
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [MAP_W-1:0] m;
        assign m         = cfg_out_src[k*MAP_W +: MAP_W];
        assign out_oe[k] = drive_ok && src_run[m] && src_ready[m] &&
                           !(susp_act && cfg_susp_out[k]);
        assign out_val[k] = out_oe[k] & raw_clk[k];
    end
endmodule

// File: rtl/clkpm_chk.sv
module clkpm_chk
    import clkpm_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   oe_pin,
    input logic [SEL_W-1:0]       sel_pin,
    input logic                   cfg_sd_en,
    input logic                   cfg_susp_en,
    input logic [N_OUT-1:0]       cfg_susp_out,
    input logic [N_OUT*MAP_W-1:0] cfg_out_src,
    input logic [N_SRC-1:0]       src_run,
    input logic [N_SRC-1:0]       src_ready,
    input logic [N_OUT-1:0]       out_oe
);
    logic [2:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 3'd7) cyc <= cyc + 1'b1;
    end

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd3 && !$past(oe_pin, 2)) |-> (out_oe == '0)); // R1

    AST_DOWN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd4 && !$past(oe_pin, 3) && $past(cfg_sd_en)) |-> (src_run == '0)); // R2

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !src_run[i] |=> !src_ready[i]); // R3
        AST_RDY_RISE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_ready[i]) |-> src_run[i]); // R3
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        AST_OUT_SRC_OK: assert property (@(posedge clk) disable iff (!rst_n)
            out_oe[k] |-> (src_run[cfg_out_src[k*MAP_W +: MAP_W]] &&
                           src_ready[cfg_out_src[k*MAP_W +: MAP_W]])); // R4
        AST_SUSP_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc >= 3'd3 && cfg_susp_en && !$past(sel_pin[SEL_W-1], 2) && cfg_susp_out[k])
            |-> !out_oe[k]); // R5
    end
endmodule

bind clkpm_ctrl clkpm_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .oe_pin       (oe_pin),
    .sel_pin      (sel_pin),
    .cfg_sd_en    (cfg_sd_en),
    .cfg_susp_en  (cfg_susp_en),
    .cfg_susp_out (cfg_susp_out),
    .cfg_out_src  (cfg_out_src),
    .src_run      (src_run),
    .src_ready    (src_ready),
    .out_oe       (out_oe)
);

// File: tb/sim_clkpm_ctrl.sv
`timescale 1ns/1ps
module sim_clkpm_ctrl;
    localparam int TDIV = 8;
    localparam int W_REF = 2, W_CPU = 50, W_SYS = 1, W_UTIL = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        oe_pin = 1'b1;
    logic [2:0]  sel_pin = 3'b101;
    logic        cfg_sd_en = 1'b1;
    logic        cfg_susp_en = 1'b0;
    logic [2:0]  cfg_susp_src = '0;
    logic [5:0]  cfg_susp_out = '0;
    logic [11:0] cfg_out_src;
    logic [5:0]  raw_clk = 6'h3F;
    logic [2:0]  sel_out;
    logic [3:0]  src_run, src_ready;
    logic [5:0]  out_oe, out_val;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    clkpm_ctrl #(.TICK_DIV(TDIV), .WAIT_REF(W_REF), .WAIT_CPU(W_CPU),
                 .WAIT_SYS(W_SYS), .WAIT_UTIL(W_UTIL)) u0 (
        .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .sel_pin(sel_pin),
        .cfg_sd_en(cfg_sd_en), .cfg_susp_en(cfg_susp_en),
        .cfg_susp_src(cfg_susp_src), .cfg_susp_out(cfg_susp_out),
        .cfg_out_src(cfg_out_src), .raw_clk(raw_clk), .sel_out(sel_out),
        .src_run(src_run), .src_ready(src_ready), .out_oe(out_oe), .out_val(out_val));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_run(input logic oe, input logic sd, input logic se,
                                           input logic s2, input logic [2:0] ssrc);
        logic down, act;
        logic [3:0] r;
        down = !oe && sd;
        act  = se && !s2;
        r[0] = !down;
        for (int i = 1; i < 4; i++) r[i] = !down && !(act && ssrc[i-1]);
        return r;
    endfunction

    function automatic logic [5:0] exp_oe(input logic oe, input logic se, input logic s2,
                                          input logic [5:0] sout, input logic [11:0] map,
                                          input logic [3:0] run);
        logic act;
        logic [5:0] o;
        act = se && !s2;
        for (int k = 0; k < 6; k++) o[k] = oe && run[map[2*k +: 2]] && !(act && sout[k]);
        return o;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] er;
        logic [5:0] eo;
        int unused_seed;
        unused_seed = $urandom(32'h1F3A);
        // out5 ref, out4 sys, out3 util, out2 sys, out1 sys, out0 cpu
        cfg_out_src = {2'd0, 2'd2, 2'd3, 2'd2, 2'd2, 2'd1};
        @(negedge clk);
        step(3);
        check("R9 out_oe", 12'(out_oe), 12'h0);
        check("R9 src_ready", 12'(src_ready), 12'h0);
        check("R9 src_run", 12'(src_run), 12'hF);
        rst_n = 1'b1;
        step(W_CPU * TDIV + 8);
        check("R3 all ready", 12'(src_ready), 12'hF);
        check("R8 out_val", 12'(out_val), 12'h3F);
        check("R7 sel_out", 12'(sel_out), 12'h5);

        // R1 / R2: tri-state only
        cfg_sd_en = 1'b0; oe_pin = 1'b0;
        step(2);
        check("R1 out_oe", 12'(out_oe), 12'h0);
        check("R1 out_val", 12'(out_val), 12'h0);
        step(8);
        check("R2 oe-only run", 12'(src_run), 12'hF);
        check("R2 oe-only ready", 12'(src_ready), 12'hF);
        oe_pin = 1'b1;
        step(4);
        check("R2 resume no relock", 12'(out_oe), 12'h3F);

        // R2 / R3: full shutdown and relock
        cfg_sd_en = 1'b1; oe_pin = 1'b0;
        step(10);
        check("R2 down run", 12'(src_run), 12'h0);
        check("R2 down ready", 12'(src_ready), 12'h0);
        check("R1 down out_val", 12'(out_val), 12'h0);
        oe_pin = 1'b1;
        step((W_CPU - 1) * TDIV);
        check("R3 cpu still locking", 12'(src_ready), 12'hD);
        check("R4 cpu outputs held", 12'(out_oe), 12'h3E);
        step(TDIV + 4);
        check("R3 cpu locked", 12'(src_ready), 12'hF);
        check("R4 all outputs", 12'(out_oe), 12'h3F);

        // R5 / R6: suspend system source, mask ref output
        cfg_susp_en = 1'b1; cfg_susp_src = 3'b010; cfg_susp_out = 6'b100000;
        sel_pin = 3'b011;
        step(4);
        check("R5 run", 12'(src_run), 12'hB);
        check("R3 sys ready cleared", 12'(src_ready[2]), 12'h0);
        check("R6 forced off", 12'(out_oe), 12'h09);
        check("R7 sel masked", 12'(sel_out), 12'h3);

        // R7: suspend disabled, bit 2 is plain select
        cfg_susp_en = 1'b0;
        step(W_SYS * TDIV + 8);
        check("R7 no suspend run", 12'(src_run), 12'hF);
        check("R7 no suspend oe", 12'(out_oe), 12'h3F);
        sel_pin = 3'b100;
        step(2);
        check("R7 sel pass", 12'(sel_out), 12'h4);

        // random rounds
        for (int it = 0; it < 60; it++) begin
            oe_pin       = ($urandom % 4) != 0;
            cfg_sd_en    = 1'($urandom);
            cfg_susp_en  = 1'($urandom);
            sel_pin      = 3'($urandom);
            cfg_susp_src = 3'($urandom);
            cfg_susp_out = 6'($urandom);
            cfg_out_src  = 12'($urandom);
            raw_clk      = 6'($urandom);
            step(W_CPU * TDIV + 8);
            er = exp_run(oe_pin, cfg_sd_en, cfg_susp_en, sel_pin[2], cfg_susp_src);
            eo = exp_oe(oe_pin, cfg_susp_en, sel_pin[2], cfg_susp_out, cfg_out_src, er);
            check("R2 R5 rand run", 12'(src_run), 12'(er));
            check("R3 rand ready", 12'(src_ready), 12'(er));
            check("R4 R6 rand oe", 12'(out_oe), 12'(eo));
            check("R8 rand val", 12'(out_val), 12'(eo & raw_clk));
            check("R7 rand sel", 12'(sel_out),
                  12'({sel_pin[2] & ~cfg_susp_en, sel_pin[1:0]}));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule